// File: doc/BRIEF.md
# Event Status Bank with Clear-on-Read and Maskable Interrupts

This block collects single-cycle event pulses into three 16-bit status registers: a master register, a loopback-detector register and a DMA register. Each event pulse latches its bit to 1, and the bit stays set until software reads that register. A read returns the register contents and clears them in the same cycle, so no event can be lost between the read and the clear.

Each status register has a companion mask register that decides, bit by bit, whether a latched bit raises an interrupt. Masking only affects the interrupt; the status bits keep recording events either way. Two active-low interrupt lines come out of the block. The host-bus line asserts whenever any unmasked status bit is set. The local-bus line follows the same condition, but only while the configuration-mode input is high.

Software uses a simple strobe interface: a 2-bit address picks the register (0 master, 1 loopback detector, 2 DMA, 3 unused), and a space-select input picks the status bank (0) or the mask bank (1). Read data appears one cycle after the read strobe.

Top module: `stat_irq_ctrl`

## Requirements
- R1: An event pulse on input bit 16*k+i sets bit i of status register k (k = 0 master, 1 loopback detector, 2 DMA), and the bit stays set over any number of idle cycles until that register is read.
- R2: A read with mask_sel=0 and address k in 0..2 returns status register k on rd_data in the cycle after rd_en, and clears the register; a second read with no new event returns 0. rd_data is 0 in any cycle that does not follow a read.
- R3: An event that arrives in the same cycle as a read of its register is not lost: the bit is set after the read and appears in the next read of that register.
- R4: With mask_sel=1 and address k in 0..2, a write stores wr_data into mask register k (bit value 1 means the bit may interrupt) and a read returns it in the cycle after rd_en.
- R5: Status bits latch events even while their mask bits are 0, and such bits never assert an interrupt.
- R6: host_irq_n is low in a cycle exactly when, one cycle earlier, some status bit and its mask bit were both 1.
- R7: local_irq_n is low exactly when host_irq_n would be low and cfg_mode was high one cycle earlier; otherwise it is high.
- R8: After reset all status bits are 0, all mask bits are 0 (every bit blocked) and both interrupt outputs are high.
- R9: Address 3 reads return 0 in both banks and writes there are ignored; writes with mask_sel=0 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_mode | input | 1 | High when the local bus is in configuration mode; enables local_irq_n |
| evt_in | input | 48 | Event pulses, 16 per status register, register k at bits 16*k+15..16*k |
| rd_en | input | 1 | One-cycle read strobe |
| wr_en | input | 1 | One-cycle write strobe (mask bank only) |
| mask_sel | input | 1 | Bank select: 0 status, 1 mask |
| addr | input | 2 | Register select: 0 master, 1 loopback detector, 2 DMA, 3 unused |
| wr_data | input | 16 | Write data for a mask register |
| rd_data | output | 16 | Read data, valid the cycle after rd_en, 0 otherwise |
| host_irq_n | output | 1 | Host-bus interrupt, active low |
| local_irq_n | output | 1 | Local-bus interrupt, active low, gated by cfg_mode |

## Verification
The bench builds the block with its default parameters: 16-bit registers, three of them and a 2-bit address, which leaves one unused address so the decode hole and ignored writes can be exercised. With only three registers of sixteen bits, random traffic frequently lands an event on the same cycle as a read of its own register and frequently toggles a mask while bits are pending, so the clear-versus-set race and the interrupt gating by mask and mode are hit many times alongside the directed cases.

// File: rtl/stat_irq_pkg.sv
package stat_irq_pkg;

    localparam int SIP_REG_W    = 16;
    localparam int SIP_NUM_REGS = 3;
    localparam int SIP_ADDR_W   = 2;

    typedef enum logic [SIP_ADDR_W-1:0] {
        SEL_MASTER = 2'd0,
        SEL_LOOP   = 2'd1,
        SEL_DMA    = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic                  rd;
        logic                  wr;
        logic                  mask_space;
        logic [SIP_ADDR_W-1:0] addr;
    } bus_req_t;

    function automatic logic addr_in_range(input logic [SIP_ADDR_W-1:0] a,
                                           input int n);
        return int'(a) < n;
    endfunction

endpackage

// File: rtl/stat_reg_decode.sv
module stat_reg_decode
    import stat_irq_pkg::*;
#(
    parameter int NUM_REGS = SIP_NUM_REGS
) (
    input  bus_req_t            req,
    output logic [NUM_REGS-1:0] stat_rd,
    output logic [NUM_REGS-1:0] mask_rd,
    output logic [NUM_REGS-1:0] mask_wr,
    output logic                hit
);

    always_comb begin
        stat_rd = '0;
        mask_rd = '0;
        mask_wr = '0;
        hit     = addr_in_range(req.addr, NUM_REGS);
        for (int k = 0; k < NUM_REGS; k++) begin
            if (hit && int'(req.addr) == k) begin
                stat_rd[k] = req.rd && !req.mask_space;
                mask_rd[k] = req.rd &&  req.mask_space;
                mask_wr[k] = req.wr &&  req.mask_space;
            end
        end
    end

endmodule

// File: rtl/stat_bank.sv
module stat_bank #(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] evt,
    input  logic             clr,
    input  logic             mask_we,
    input  logic [REG_W-1:0] mask_wd,
    output logic [REG_W-1:0] status,
    output logic [REG_W-1:0] mask,
    output logic             pending
);

    logic [REG_W-1:0] status_nx;

    // A read clears what it saw; events of the same cycle survive.
    always_comb begin
        if (clr) status_nx = evt;
        else     status_nx = status | evt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            mask   <= '0;
        end else begin
            status <= status_nx;
            if (mask_we) mask <= mask_wd;
        end
    end

    assign pending = |(status & mask);

endmodule

// File: rtl/stat_irq_out.sv
module stat_irq_out #(
    parameter int NUM_REGS = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_REGS-1:0] pend,
    input  logic                cfg_mode,
    output logic                host_irq_n,
    output logic                local_irq_n
);

    logic any_pend;
    assign any_pend = |pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            host_irq_n  <= 1'b1;
            local_irq_n <= 1'b1;
        end else begin
            host_irq_n  <= !any_pend;
            local_irq_n <= !(any_pend && cfg_mode);
        end
    end

endmodule

// File: rtl/stat_irq_ctrl.sv
module stat_irq_ctrl
    import stat_irq_pkg::*;
#(
    parameter int REG_W    = SIP_REG_W,
    parameter int NUM_REGS = SIP_NUM_REGS,
    parameter int ADDR_W   = SIP_ADDR_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cfg_mode,
    input  logic [NUM_REGS*REG_W-1:0] evt_in,
    input  logic                      rd_en,
    input  logic                      wr_en,
    input  logic                      mask_sel,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [REG_W-1:0]          wr_data,
    output logic [REG_W-1:0]          rd_data,
    output logic                      host_irq_n,
    output logic                      local_irq_n
);

    bus_req_t            req;
    logic [NUM_REGS-1:0] stat_rd, mask_rd, mask_wr, pend;
    logic                hit;
    logic [REG_W-1:0]    status_q [NUM_REGS];
    logic [REG_W-1:0]    mask_q   [NUM_REGS];
    logic [REG_W-1:0]    rd_mux;

    always_comb begin
        req.rd         = rd_en;
        req.wr         = wr_en;
        req.mask_space = mask_sel;
        req.addr       = addr;
    end

    stat_reg_decode #(.NUM_REGS(NUM_REGS)) u_dec (
        .req     (req),
        .stat_rd (stat_rd),
        .mask_rd (mask_rd),
        .mask_wr (mask_wr),
        .hit     (hit)
    );

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_bank
        stat_bank #(.REG_W(REG_W)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .evt     (evt_in[k*REG_W +: REG_W]),
            .clr     (stat_rd[k]),
            .mask_we (mask_wr[k]),
            .mask_wd (wr_data),
            .status  (status_q[k]),
            .mask    (mask_q[k]),
            .pending (pend[k])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (stat_rd[k]) rd_mux = rd_mux | status_q[k];
            if (mask_rd[k]) rd_mux = rd_mux | mask_q[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rd_data <= '0;
        else     rd_data <= (rd_en && hit) ? rd_mux : '0;
    end

    stat_irq_out #(.NUM_REGS(NUM_REGS)) u_irq (
        .clk         (clk),
        .rst         (rst),
        .pend        (pend),
        .cfg_mode    (cfg_mode),
        .host_irq_n  (host_irq_n),
        .local_irq_n (local_irq_n)
    );

endmodule

// File: rtl/stat_irq_chk.sv
module stat_irq_chk #(
    parameter int REG_W    = 16,
    parameter int NUM_REGS = 3,
    parameter int ADDR_W   = 2
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      cfg_mode,
    input logic [NUM_REGS*REG_W-1:0] evt_in,
    input logic                      rd_en,
    input logic                      wr_en,
    input logic                      mask_sel,
    input logic [ADDR_W-1:0]         addr,
    input logic [REG_W-1:0]          wr_data,
    input logic [REG_W-1:0]          rd_data,
    input logic                      host_irq_n,
    input logic                      local_irq_n
);

    logic             valid_a;
    logic             st_rd;
    logic [REG_W-1:0] evt_sel;

    always_comb begin
        valid_a = int'(addr) < NUM_REGS;
        st_rd   = rd_en && !mask_sel && valid_a;
        evt_sel = '0;
        for (int k = 0; k < NUM_REGS; k++)
            if (int'(addr) == k) evt_sel = evt_in[k*REG_W +: REG_W];
    end

    // R2: back-to-back reads with no event in between return zero
    assert_reread_empty_R2: assert property (@(posedge clk) disable iff (rst)
        (st_rd && $past(st_rd) && !$past(rst) && addr == $past(addr)
         && $past(evt_sel) == '0) |=> rd_data == '0);

    // R2: no read, no data
    assert_idle_zero_R2: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> rd_data == '0);

    // R4: mask written then read back on the next cycle
    assert_mask_readback_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && wr_en && mask_sel && valid_a) && rd_en && !wr_en
         && mask_sel && addr == $past(addr)) |=> rd_data == $past(wr_data, 2));

    // R9: unused address reads zero
    assert_hole_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !valid_a) |=> rd_data == '0);

    // R7: local line only low alongside host line
    assert_local_follows_R7: assert property (@(posedge clk) disable iff (rst)
        !local_irq_n |-> !host_irq_n);

    // R7: local line only low if configuration mode was on
    assert_local_gated_R7: assert property (@(posedge clk) disable iff (rst)
        !local_irq_n |-> $past(cfg_mode));

endmodule

bind stat_irq_ctrl stat_irq_chk #(
    .REG_W(REG_W), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/test_stat_irq_ctrl.sv
module test_stat_irq_ctrl;

    localparam int W = 16;
    localparam int N = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_mode = 1'b0;
    logic [N*W-1:0] evt_in = '0;
    logic          rd_en = 1'b0, wr_en = 1'b0, mask_sel = 1'b0;
    logic [1:0]    addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic [W-1:0]  rd_data;
    logic          host_irq_n, local_irq_n;

    int n_chk  = 0;
    int n_fail = 0;

    logic [W-1:0] m_st [N];
    logic [W-1:0] m_mk [N];

    always #5 clk = ~clk;

    stat_irq_ctrl i_stat_irq_ctrl (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .evt_in(evt_in),
        .rd_en(rd_en), .wr_en(wr_en), .mask_sel(mask_sel), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data),
        .host_irq_n(host_irq_n), .local_irq_n(local_irq_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic model_pending();
        logic p = 1'b0;
        for (int k = 0; k < N; k++) p |= |(m_st[k] & m_mk[k]);
        return p;
    endfunction

    // One clock: drive at negedge, model the edge, compare at next negedge.
    task automatic step(input logic [N*W-1:0] e, input logic rd, input logic wr,
                        input logic ms, input logic [1:0] a, input logic [W-1:0] wd);
        logic [W-1:0] exp_rd;
        logic         exp_host, exp_local;
        string        rtag;
        evt_in = e; rd_en = rd; wr_en = wr; mask_sel = ms; addr = a; wr_data = wd;
        exp_rd = '0;
        rtag   = "R2";
        if (rd) begin
            if (int'(a) >= N)  begin exp_rd = '0; rtag = "R9"; end
            else if (ms)       begin exp_rd = m_mk[a]; rtag = "R4"; end
            else                      exp_rd = m_st[a];
        end
        exp_host  = !model_pending();
        exp_local = !(model_pending() && cfg_mode);
        @(posedge clk);
        for (int k = 0; k < N; k++) begin
            if (rd && !ms && int'(a) == k) m_st[k] = e[k*W +: W];
            else                           m_st[k] = m_st[k] | e[k*W +: W];
            if (wr && ms && int'(a) == k)  m_mk[k] = wd;
        end
        @(negedge clk);
        chk(rtag, rd_data, exp_rd);
        chk("R6", host_irq_n, exp_host);
        chk("R7", local_irq_n, exp_local);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step('0, 0, 0, 0, 2'd0, '0);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        for (int k = 0; k < N; k++) begin m_st[k] = '0; m_mk[k] = '0; end
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R8: reset state
        chk("R8", host_irq_n, 1'b1);
        chk("R8", local_irq_n, 1'b1);
        for (int k = 0; k < N; k++) begin
            step('0, 1, 0, 1, 2'(k), '0);
            chk("R8", rd_data, 16'h0000);
        end

        // R5 and R1: masked event latches, no interrupt, held until read
        step(48'h1, 0, 0, 0, 2'd0, '0);
        idle(3);
        chk("R5", host_irq_n, 1'b1);
        step('0, 1, 0, 0, 2'd0, '0);
        chk("R1", rd_data, 16'h0001);
        step('0, 1, 0, 0, 2'd0, '0);
        chk("R2", rd_data, 16'h0000);

        // R3: event in the cycle of the read survives
        step(48'h1 << 21, 1, 0, 0, 2'd1, '0);
        chk("R3", rd_data, 16'h0000);
        step('0, 1, 0, 0, 2'd1, '0);
        chk("R3", rd_data, 16'h0020);

        // R6, R7: unmasked event, mode gating
        cfg_mode = 1'b0;
        step('0, 0, 1, 1, 2'd2, 16'h8000);
        step(48'h1 << 47, 0, 0, 0, 2'd0, '0);
        idle(2);
        chk("R6", host_irq_n, 1'b0);
        chk("R7", local_irq_n, 1'b1);
        cfg_mode = 1'b1;
        idle(2);
        chk("R7", local_irq_n, 1'b0);
        step('0, 1, 0, 0, 2'd2, '0);
        chk("R1", rd_data, 16'h8000);
        idle(2);
        chk("R6", host_irq_n, 1'b1);

        // R9: hole address and writes to the status bank
        step('0, 0, 1, 1, 2'd3, 16'hFFFF);
        step('0, 0, 1, 0, 2'd0, 16'hFFFF);
        step('0, 1, 0, 1, 2'd3, '0);
        chk("R9", rd_data, 16'h0000);
        step('0, 1, 0, 0, 2'd0, '0);
        chk("R9", rd_data, 16'h0000);
        step('0, 1, 0, 1, 2'd0, '0);
        chk("R9", rd_data, 16'h0000);

        // Random traffic checked against the model
        for (int i = 0; i < 3000; i++) begin
            logic [N*W-1:0] e;
            logic [31:0]    r;
            e = {$urandom & $urandom & $urandom & $urandom,
                 $urandom & $urandom & $urandom & $urandom};
            r = $urandom;
            if (r[31:28] == 4'h0) cfg_mode = ~cfg_mode;
            step(e, r[0] | r[1], r[2] & r[3], r[4] & r[5], r[7:6],
                 W'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule